// File: doc/BRIEF.md
# Fault-Vectored Priority Interrupt Controller

This block gathers the processor's internal interrupt sources and turns them into one request line with a vector number. Sixteen low vectors are kept for sources inside the processor: vector 0 belongs to the periodic timer, and each of vectors 1 to 15 belongs to one fault condition. Every fault has its own input wire. Handler software can therefore read the vector and know exactly which fault fired, instead of seeing a single merged fault signal.

Each source is captured on its rising edge into a pending bit. The pending bit stays set until the processor acknowledges that vector. A software interrupt can name any of the sixteen reserved vectors. It sets the same pending bit, so the handler cannot tell it apart from the hardware event. Priority is fixed: a higher vector number is more severe and wins, and the timer is served only when no fault is pending.

A single external request with its own vector is passed through at the lowest priority. It is presented only when no internal bit is pending. A global enable blocks the request output while pending bits keep collecting.

Top module: `fvic_top`

## Requirements
- R1: While reset is asserted and right after it is released, `irq` is 0, `vecOut` is 0 and no vector is pending.
- R2: A 0-to-1 transition on `timerTick` makes vector 0 pending, and one on `faultIn[k-1]` makes vector k pending (k = 1..15), visible after the clock edge that samples it. A line held high does not pend its vector again.
- R3: When `irq` is 1 and internal vectors are pending, `vecOut` is the highest-numbered pending vector, so any pending fault is presented ahead of the timer.
- R4: `intAck` sampled high while `irq` is 1 clears only the pending bit of the vector being presented. The next-highest pending vector appears after that edge, and all other pending bits are unchanged.
- R5: `swReq` sampled high makes the vector named by `swVec` (0..15) pending. That vector is then arbitrated exactly like a hardware source.
- R6: While `intEn` is 0, `irq` is 0, sources keep setting pending bits, and `intAck` clears nothing. When `intEn` returns to 1, the pending vectors are presented.
- R7: When no internal vector is pending and `extReq` is 1, `irq` is 1 and `vecOut` equals `extVec`. Any pending internal vector takes precedence. An acknowledge while the external vector is presented clears no internal bit.
- R8: If a vector's source rises in the same cycle that the vector is acknowledged, the vector stays pending.
- R9: `vecOut` is 0 whenever `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultIn | input | 15 | Fault lines; bit k-1 maps to vector k |
| timerTick | input | 1 | Timer request, vector 0 |
| swReq | input | 1 | Software interrupt strobe |
| swVec | input | 4 | Vector named by the software interrupt |
| extReq | input | 1 | External device request, lowest priority |
| extVec | input | 8 | Vector passed through for the external request |
| intEn | input | 1 | Global interrupt enable |
| intAck | input | 1 | Acknowledge of the presented vector |
| irq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Presented vector number |

## Verification
The assertions assume that every input is synchronous to `clk` and steady across each sampling edge. They also assume that `swVec` always names a reserved vector, which its width guarantees. They take no position on how long a fault line stays high, because only rising transitions count. The stimulus changes inputs only on the falling clock edge. It holds fault lines high across several cycles to show that a steady level adds nothing. It places a new rise and an acknowledge of the same vector in one cycle on purpose, to reach the case where setting and clearing collide.

// File: rtl/fvic_pkg.sv
package fvic_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic irqOn;   // request is being presented this cycle
    logic useExt;  // the external vector is the one presented
    logic clrSel;  // drop the presented internal vector at the next edge
  } ctrl_strb_t;
endpackage

// File: rtl/fvic_prio.sv
module fvic_prio #(
  parameter int NUM_INT = 16,
  localparam int IDX_W = $clog2(NUM_INT)
) (
  input  logic [NUM_INT-1:0] pendIn,
  output logic               anyPend,
  output logic [IDX_W-1:0]   selIdx
);
  // The highest set index wins, which puts the timer (bit 0) last.
  always_comb begin
    selIdx = '0;
    for (int i = 0; i < NUM_INT; i++) begin
      if (pendIn[i]) selIdx = IDX_W'(i);
    end
  end

  assign anyPend = |pendIn;

  always_comb begin
    if (anyPend) begin
      AST_PRIO_TOP : assert (pendIn[selIdx] && ((pendIn >> selIdx) == NUM_INT'(1))); // R3
    end
  end
endmodule

// File: rtl/fvic_ctrl.sv
module fvic_ctrl
  import fvic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intEn,
  input  logic       intAck,
  input  logic       extReq,
  input  logic       anyPend,
  output ctrl_strb_t strb
);
  always_comb begin
    strb.irqOn  = intEn && (anyPend || extReq);
    strb.useExt = !anyPend && extReq;
    strb.clrSel = intAck && intEn && anyPend;
  end

  AST_ACK_NEEDS_EN : assert property (@(posedge clk) disable iff (!rstN)
    strb.clrSel |-> (strb.irqOn && !strb.useExt)); // R6

  AST_EXT_ACK_KEEPS : assert property (@(posedge clk) disable iff (!rstN)
    (strb.useExt && intAck) |-> !strb.clrSel); // R7
endmodule

// File: rtl/fvic_dp.sv
module fvic_dp
  import fvic_pkg::*;
#(
  parameter int NUM_INT = 16,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_INT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_INT-1:0] srcNow,
  input  logic               swReq,
  input  logic [IDX_W-1:0]   swVec,
  input  logic [VEC_W-1:0]   extVec,
  input  ctrl_strb_t         strb,
  output logic               anyPend,
  output logic [VEC_W-1:0]   vecOut
);
  logic [NUM_INT-1:0] srcPrev;
  logic [NUM_INT-1:0] pending;
  logic [NUM_INT-1:0] riseMask;
  logic [NUM_INT-1:0] swMask;
  logic [NUM_INT-1:0] clrMask;
  logic [IDX_W-1:0]   selIdx;

  fvic_prio #(.NUM_INT(NUM_INT)) i_prio (
    .pendIn (pending),
    .anyPend(anyPend),
    .selIdx (selIdx)
  );

  assign riseMask = srcNow & ~srcPrev;

  generate
    for (genvar g = 0; g < NUM_INT; g++) begin : g_bit
      assign swMask[g]  = swReq && (swVec == IDX_W'(g));
      assign clrMask[g] = strb.clrSel && (selIdx == IDX_W'(g));

      // A new event in the same cycle as the acknowledge keeps the bit set.
      always_ff @(posedge clk) begin
        if (!rstN) begin
          srcPrev[g] <= 1'b0;
          pending[g] <= 1'b0;
        end else begin
          srcPrev[g] <= srcNow[g];
          pending[g] <= (pending[g] && !clrMask[g]) || riseMask[g] || swMask[g];
        end
      end

      AST_RISE_PENDS : assert property (@(posedge clk) disable iff (!rstN)
        (srcNow[g] && !srcPrev[g]) |=> pending[g]); // R2

      AST_HOLD_TILL_ACK : assert property (@(posedge clk) disable iff (!rstN)
        (pending[g] && !(strb.clrSel && selIdx == IDX_W'(g))) |=> pending[g]); // R4
    end
  endgenerate

  always_comb begin
    if (!strb.irqOn)      vecOut = '0;
    else if (strb.useExt) vecOut = extVec;
    else                  vecOut = VEC_W'(selIdx);
  end

  AST_SW_PENDS : assert property (@(posedge clk) disable iff (!rstN)
    swReq |=> pending[$past(swVec)]); // R5

  AST_NO_STRAY_CLEAR : assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrSel |=> ((~pending & $past(pending)) == '0)); // R6

  AST_ONE_CLEAR : assert property (@(posedge clk) disable iff (!rstN)
    strb.clrSel |=> ($countones(~pending & $past(pending)) <= 1)); // R4
endmodule

// File: rtl/fvic_top.sv
module fvic_top #(
  parameter int NUM_INT = 16,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_INT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_INT-2:0] faultIn,
  input  logic               timerTick,
  input  logic               swReq,
  input  logic [IDX_W-1:0]   swVec,
  input  logic               extReq,
  input  logic [VEC_W-1:0]   extVec,
  input  logic               intEn,
  input  logic               intAck,
  output logic               irq,
  output logic [VEC_W-1:0]   vecOut
);
  import fvic_pkg::*;

  ctrl_strb_t strb;
  logic       anyPend;

  fvic_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .intEn  (intEn),
    .intAck (intAck),
    .extReq (extReq),
    .anyPend(anyPend),
    .strb   (strb)
  );

  fvic_dp #(.NUM_INT(NUM_INT), .VEC_W(VEC_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcNow ({faultIn, timerTick}),
    .swReq  (swReq),
    .swVec  (swVec),
    .extVec (extVec),
    .strb   (strb),
    .anyPend(anyPend),
    .vecOut (vecOut)
  );

  assign irq = strb.irqOn;

  AST_IDLE_VEC_ZERO : assert property (@(posedge clk) !irq |-> (vecOut == '0)); // R9

  AST_RESET_QUIET : assert property (@(posedge clk) $past(!rstN) |-> !anyPend); // R1
endmodule

// File: tb/test_fvic_top.sv
module test_fvic_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [14:0] faultIn;
  logic        timerTick, swReq, extReq, intEn, intAck;
  logic [3:0]  swVec;
  logic [7:0]  extVec;
  logic        irq;
  logic [7:0]  vecOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  fvic_top i_fvic_top (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .timerTick(timerTick),
    .swReq(swReq), .swVec(swVec), .extReq(extReq), .extVec(extVec),
    .intEn(intEn), .intAck(intAck), .irq(irq), .vecOut(vecOut)
  );

  typedef struct packed {
    logic [14:0] flt;
    logic        tmr;
    logic        sw;
    logic [3:0]  swv;
    logic        ext;
    logic [7:0]  extv;
    logic        en;
    logic        ack;
    logic        eIrq;
    logic [7:0]  eVec;
  } row_t;

  localparam int NROW = 27;
  localparam row_t TBL [NROW] = '{
    '{15'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, //  0 R9 idle
    '{15'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00}, //  1 R2 timer
    '{15'h0004, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h03}, //  2 R3 fault over timer
    '{15'h0104, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h09}, //  3 R3 higher fault
    '{15'h0104, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h03}, //  4 R4 ack 9
    '{15'h0104, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h03}, //  5 R2 held level
    '{15'h0104, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00}, //  6 R4 ack 3
    '{15'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00}, //  7 R4 timer kept
    '{15'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00}, //  8 R9 empty
    '{15'h4000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, //  9 R6 disabled
    '{15'h4000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // 10 R6 ack ignored
    '{15'h4000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0F}, // 11 R6 re-enabled
    '{15'h4000, 1'b0, 1'b1, 4'h5, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0F}, // 12 R5 sw 5 lower
    '{15'h4000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h05}, // 13 R5 sw 5 shown
    '{15'h4000, 1'b0, 1'b1, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h05}, // 14 R5 sw 0
    '{15'h4000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00}, // 15 R5 sw 0 shown
    '{15'h4000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00}, // 16 R4 all acked
    '{15'h4000, 1'b0, 1'b0, 4'h0, 1'b1, 8'h40, 1'b1, 1'b0, 1'b1, 8'h40}, // 17 R7 external
    '{15'h4001, 1'b0, 1'b0, 4'h0, 1'b1, 8'h40, 1'b1, 1'b0, 1'b1, 8'h01}, // 18 R7 internal first
    '{15'h4001, 1'b0, 1'b0, 4'h0, 1'b1, 8'h40, 1'b1, 1'b1, 1'b1, 8'h40}, // 19 R7 back to ext
    '{15'h4001, 1'b0, 1'b0, 4'h0, 1'b1, 8'h40, 1'b1, 1'b1, 1'b1, 8'h40}, // 20 R7 ext ack
    '{15'h4001, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // 21 R7 nothing left
    '{15'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // 22 R9 lines low
    '{15'h0002, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h02}, // 23 R2 vector 2
    '{15'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h02}, // 24 R2 falling ignored
    '{15'h0002, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h02}, // 25 R8 rise with ack
    '{15'h0002, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00}  // 26 R8 then cleared
  };

  function automatic string tagOf(int row);
    case (row)
      1, 5, 23, 24:              return "R2";
      2, 3:                      return "R3";
      4, 6, 7, 16:               return "R4";
      12, 13, 14, 15:            return "R5";
      9, 10, 11:                 return "R6";
      17, 18, 19, 20, 21:        return "R7";
      25, 26:                    return "R8";
      default:                   return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(row_t r);
    faultIn = r.flt; timerTick = r.tmr; swReq = r.sw; swVec = r.swv;
    extReq = r.ext; extVec = r.extv; intEn = r.en; intAck = r.ack;
  endtask

  initial begin
    rstN = 1'b0;
    drive('0);
    intEn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "irq in reset", {7'd0, irq}, 8'h00);
    check("R1", "vec in reset", vecOut, 8'h00);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", "irq after reset", {7'd0, irq}, 8'h00);
    check("R1", "vec after reset", vecOut, 8'h00);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk) drive(TBL[i]);
      @(posedge clk); #1;
      check(tagOf(i), $sformatf("row %0d irq", i), {7'd0, irq}, {7'd0, TBL[i].eIrq});
      check(tagOf(i), $sformatf("row %0d vec", i), vecOut, TBL[i].eVec);
    end

    // R1: reset drops a pending vector.
    @(negedge clk) begin drive('0); intEn = 1'b1; timerTick = 1'b1; end
    @(posedge clk); #1;
    check("R2", "timer before reset", {7'd0, irq}, 8'h01);
    @(negedge clk) rstN = 1'b0;
    @(posedge clk); #1;
    check("R1", "irq reset clears", {7'd0, irq}, 8'h00);
    @(negedge clk) begin rstN = 1'b1; timerTick = 1'b0; end
    @(posedge clk); #1;
    check("R1", "irq stays clear", {7'd0, irq}, 8'h00);
    check("R1", "vec stays clear", vecOut, 8'h00);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule